// File: doc/BRIEF.md
# Serial Flash Status-Register Write Guard

This block is the slave-side command front end that a serial flash uses to write its status register. Commands arrive on an active-low chip select, a serial clock and a serial data input. Two commands are decoded. The first is a one-byte write-enable, opcode 0x06. The second is a two-byte status write, opcode 0x01 followed by one data byte. Bits are taken most significant first on rising serial-clock edges. Either idle clock level (SPI mode 0 or mode 3) is accepted.

A frame-classifier state machine runs on the serial clock. Its states are FS_OPCODE, FS_DATA, FS_WREN_OK, FS_WRSR_OK and FS_DISCARD. Its transitions are:

- FS_OPCODE to FS_WREN_OK when the eighth bit completes opcode 0x06.
- FS_OPCODE to FS_DATA when the eighth bit completes opcode 0x01.
- FS_OPCODE to FS_DISCARD when the eighth bit completes any other opcode.
- FS_DATA to FS_WRSR_OK when the eighth data bit arrives.
- FS_WREN_OK, FS_WRSR_OK or FS_DISCARD to FS_DISCARD on any further bit.

While chip select is high, the machine is held in FS_OPCODE with its bit counter at zero. Nothing changes the stored register while bits are being shifted. On the rising edge of chip select, the final state decides what happens:

- FS_WREN_OK sets the write-enable latch.
- FS_WRSR_OK makes a status write attempt.
- Every other state leaves the register alone.

A status write attempt is accepted only when the write-enable latch is set and one of two conditions holds: the write-protect input is high, or the lock-down bit is clear. The serial-output drive enable stays low, so the output pin remains in high impedance for both commands.

Top module: `spi_status_guard`

## Requirements
- R1: While rst_n is low, status reads 0x00.
- R2: Opcode and data bits are sampled on rising sck edges, most significant bit first, and frames work whether sck idles low (mode 0) or high (mode 3) when chip select falls.
- R3: A frame of exactly 8 bits carrying 0x06 sets the write-enable latch, status bit 1, at the chip-select rising edge.
- R4: An accepted status write loads data bits 7, 5, 4, 3 and 2 into status bits 7 (lock-down), 5 (top/bottom) and 4:2 (block protect). Status bit 6 and busy bit 0 stay 0 whatever the data holds.
- R5: A status write is discarded when wp_n is low and lock-down is already 1.
- R6: With wp_n low and lock-down 0, a single status write may set lock-down to 1 and change the other writable bits together.
- R7: A status write frame arriving while the write-enable latch is clear leaves status bits 7:2 unchanged.
- R8: Every exactly 16-bit frame opening with 0x01 clears the write-enable latch, whether or not the write was accepted.
- R9: Frames of any other bit count, and 8-bit frames with an unknown opcode, change neither the status bits nor the write-enable latch.
- R10: Status does not change while chip select is still low after the last bit; the update appears only after chip select rises.
- R11: so_oe stays 0 throughout all frames.
- R12: A frame aborted part-way by chip select rising does not disturb the next frame, which starts again from bit zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_n | input | 1 | Asynchronous active-low reset of the stored register |
| cs_n | input | 1 | Active-low chip select; its rising edge commits a frame |
| sck | input | 1 | Serial clock; rising edges sample si |
| si | input | 1 | Serial data in, most significant bit first |
| wp_n | input | 1 | Hardware write protect; low guards a locked register |
| status | output | 8 | Status register: 7 lock-down, 5 top/bottom, 4:2 block protect, 1 write-enable latch, 0 busy |
| so_oe | output | 1 | Serial-output drive enable, held low (pin in high impedance) |

## Verification
A wrong classifier state does not show at once. It shows at the next chip-select rising edge, either as a write-enable latch that fails to set or clear, or as protect bits that change when they should not. A stray write reaches the ports one chip-select edge after the faulty frame. A guard that lets a locked register through shows up the same way: status bits 7:2 differ at the first sample after chip select rises. Because every commit is tied to that edge, the bench checks status before and after each rise, so a premature update is caught while chip select is still low.

// File: rtl/spi_status_guard_pkg.sv
package spi_status_guard_pkg;

    localparam int unsigned BYTE_W = 8;

    localparam logic [BYTE_W-1:0] OPC_WREN = 8'h06;
    localparam logic [BYTE_W-1:0] OPC_WRSR = 8'h01;

    // status bit positions; a neighbour reading the register decodes these
    localparam int unsigned LOCK_POS  = 7;
    localparam int unsigned TB_POS    = 5;
    localparam int unsigned BP_HI_POS = 4;
    localparam int unsigned BP_LO_POS = 2;
    localparam int unsigned WEL_POS   = 1;
    localparam int unsigned BP_W      = BP_HI_POS - BP_LO_POS + 1;

    typedef enum logic [2:0] {
        FS_OPCODE  = 3'd0,
        FS_DATA    = 3'd1,
        FS_WREN_OK = 3'd2,
        FS_WRSR_OK = 3'd3,
        FS_DISCARD = 3'd4
    } frame_st_e;

endpackage

// File: rtl/sr_frame_fsm.sv
module sr_frame_fsm
    import spi_status_guard_pkg::*;
#(
    parameter int unsigned W = BYTE_W
) (
    input  logic         sck,
    input  logic         cs_n,
    input  logic         si,
    output frame_st_e    frame_st,
    output logic [W-1:0] last_byte
);
    localparam int unsigned CNT_W = $clog2(W);

    frame_st_e          st_q, st_d;
    logic [CNT_W-1:0]   cnt_q, cnt_d;
    logic [W-1:0]       sh_q, sh_d;
    logic               byte_end;

    // state register; chip select high holds the frame at bit zero (R12)
    always_ff @(posedge sck or posedge cs_n) begin
        if (cs_n) begin
            st_q  <= FS_OPCODE;
            cnt_q <= '0;
            sh_q  <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
            sh_q  <= sh_d;
        end
    end

    always_comb begin
        sh_d     = {sh_q[W-2:0], si};
        cnt_d    = cnt_q + CNT_W'(1);
        byte_end = (cnt_q == CNT_W'(W-1));
        st_d     = st_q;
        unique case (st_q)
            FS_OPCODE: begin
                if (byte_end) begin
                    if (sh_d == OPC_WREN)      st_d = FS_WREN_OK;
                    else if (sh_d == OPC_WRSR) st_d = FS_DATA;
                    else                       st_d = FS_DISCARD;
                end
            end
            FS_DATA: begin
                if (byte_end) st_d = FS_WRSR_OK;
            end
            FS_WREN_OK, FS_WRSR_OK, FS_DISCARD: st_d = FS_DISCARD;
            default: st_d = FS_DISCARD;
        endcase
    end

    assign frame_st  = st_q;
    assign last_byte = sh_q;

endmodule

// File: rtl/sr_guard.sv
module sr_guard (
    input  logic wel,
    input  logic lock,
    input  logic wp_n,
    output logic accept
);
    // write passes if enabled and either pin high or lock clear
    always_comb begin
        accept = wel && (wp_n || !lock);
    end
endmodule

// File: rtl/sr_store.sv
module sr_store
    import spi_status_guard_pkg::*;
(
    input  logic              rst_n,
    input  logic              cs_n,
    input  frame_st_e         frame_st,
    input  logic [BYTE_W-1:0] wr_byte,
    input  logic              accept,
    output logic              lock,
    output logic              wel,
    output logic [BYTE_W-1:0] status
);
    logic            tb_q;
    logic [BP_W-1:0] bp_q;

    // commit process: acts once per chip-select rising edge (R10)
    always_ff @(posedge cs_n or negedge rst_n) begin
        if (!rst_n) begin
            lock <= 1'b0;
            tb_q <= 1'b0;
            bp_q <= '0;
            wel  <= 1'b0;
        end else begin
            unique case (frame_st)
                FS_WREN_OK: wel <= 1'b1;
                FS_WRSR_OK: begin
                    wel <= 1'b0;
                    if (accept) begin
                        lock <= wr_byte[LOCK_POS];
                        tb_q <= wr_byte[TB_POS];
                        bp_q <= wr_byte[BP_HI_POS:BP_LO_POS];
                    end
                end
                default: ;
            endcase
        end
    end

    // output process
    always_comb begin
        status                       = '0;
        status[LOCK_POS]             = lock;
        status[TB_POS]               = tb_q;
        status[BP_HI_POS:BP_LO_POS]  = bp_q;
        status[WEL_POS]              = wel;
    end
endmodule

// File: rtl/spi_status_guard.sv
module spi_status_guard
    import spi_status_guard_pkg::*;
(
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sck,
    input  logic              si,
    input  logic              wp_n,
    output logic [BYTE_W-1:0] status,
    output logic              so_oe
);
    frame_st_e         frame_st;
    logic [BYTE_W-1:0] last_byte;
    logic              lock, wel, accept;

    sr_frame_fsm #(.W(BYTE_W)) u_fsm (
        .sck       (sck),
        .cs_n      (cs_n),
        .si        (si),
        .frame_st  (frame_st),
        .last_byte (last_byte)
    );

    sr_guard u_guard (
        .wel    (wel),
        .lock   (lock),
        .wp_n   (wp_n),
        .accept (accept)
    );

    sr_store u_store (
        .rst_n    (rst_n),
        .cs_n     (cs_n),
        .frame_st (frame_st),
        .wr_byte  (last_byte),
        .accept   (accept),
        .lock     (lock),
        .wel      (wel),
        .status   (status)
    );

    // neither command returns data: output driver stays off (R11)
    assign so_oe = 1'b0;

endmodule

// File: rtl/spi_status_guard_chk.sv
module spi_status_guard_chk
    import spi_status_guard_pkg::*;
(
    input logic              rst_n,
    input logic              cs_n,
    input logic              sck,
    input logic              wp_n,
    input logic [BYTE_W-1:0] status,
    input logic [BYTE_W-1:0] last_byte,
    input frame_st_e         frame_st
);
    a_r3_wren_sets_latch: assert property (@(posedge cs_n) disable iff (!rst_n)
        (frame_st == FS_WREN_OK) |=> status[WEL_POS]);

    a_r8_wrsr_clears_latch: assert property (@(posedge cs_n) disable iff (!rst_n)
        (frame_st == FS_WRSR_OK) |=> !status[WEL_POS]);

    a_r5_locked_frozen: assert property (@(posedge cs_n) disable iff (!rst_n)
        (!wp_n && status[LOCK_POS]) |=> $stable(status[7:2]));

    a_r7_no_latch_no_write: assert property (@(posedge cs_n) disable iff (!rst_n)
        !status[WEL_POS] |=> $stable(status[7:2]));

    a_r9_bad_frame_ignored: assert property (@(posedge cs_n) disable iff (!rst_n)
        (frame_st == FS_DISCARD || frame_st == FS_OPCODE || frame_st == FS_DATA)
        |=> $stable(status));

    a_r4_accepted_loads: assert property (@(posedge cs_n) disable iff (!rst_n)
        (frame_st == FS_WRSR_OK && status[WEL_POS] && wp_n)
        |=> (status[7:2] == {$past(last_byte[7]), 1'b0, $past(last_byte[5:2])}));

    a_r12_discard_sticky: assert property (@(posedge sck) disable iff (cs_n)
        (frame_st == FS_DISCARD) |=> (frame_st == FS_DISCARD));
endmodule

bind spi_status_guard spi_status_guard_chk u_chk (
    .rst_n     (rst_n),
    .cs_n      (cs_n),
    .sck       (sck),
    .wp_n      (wp_n),
    .status    (status),
    .last_byte (last_byte),
    .frame_st  (frame_st)
);

// File: tb/test_spi_status_guard.sv
module test_spi_status_guard;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1;
    logic sck = 1'b0;
    logic si = 1'b0;
    logic wp_n = 1'b1;
    logic [7:0] status;
    logic so_oe;

    int n_chk = 0;
    int n_bad = 0;
    logic done = 1'b0;

    always #2 clk = ~clk;

    spi_status_guard i_spi_status_guard (
        .rst_n  (rst_n),
        .cs_n   (cs_n),
        .sck    (sck),
        .si     (si),
        .wp_n   (wp_n),
        .status (status),
        .so_oe  (so_oe)
    );

    typedef struct packed {
        logic [3:0]  req;
        logic [4:0]  nb;
        logic [15:0] bits;
        logic        m3;
        logic        wp;
        logic [7:0]  exp;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VT [NV] = '{
        '{4'd3,  5'd8,  16'h0600, 1'b0, 1'b1, 8'h02},  // R3 enable
        '{4'd4,  5'd16, 16'h019C, 1'b0, 1'b1, 8'h9C},  // R4 lock + protect
        '{4'd2,  5'd8,  16'h0600, 1'b1, 1'b1, 8'h9E},  // R2 mode 3 enable
        '{4'd5,  5'd16, 16'h0100, 1'b1, 1'b0, 8'h9C},  // R5 locked, wp low; R8 latch clears
        '{4'd3,  5'd8,  16'h0600, 1'b0, 1'b0, 8'h9E},  // R3
        '{4'd4,  5'd16, 16'h0100, 1'b0, 1'b1, 8'h00},  // R4 wp high unlocks
        '{4'd7,  5'd16, 16'h01BC, 1'b0, 1'b1, 8'h00},  // R7 no latch
        '{4'd3,  5'd8,  16'h0600, 1'b1, 1'b0, 8'h02},  // R3
        '{4'd6,  5'd16, 16'h01A4, 1'b0, 1'b0, 8'hA4},  // R6 lock set with wp low
        '{4'd9,  5'd9,  16'h0680, 1'b0, 1'b1, 8'hA4},  // R9 nine bits
        '{4'd9,  5'd7,  16'h0600, 1'b0, 1'b1, 8'hA4},  // R9 seven bits
        '{4'd9,  5'd8,  16'h0500, 1'b1, 1'b1, 8'hA4},  // R9 unknown opcode
        '{4'd3,  5'd8,  16'h0600, 1'b0, 1'b1, 8'hA6},  // R3
        '{4'd9,  5'd15, 16'h01FF, 1'b0, 1'b1, 8'hA6},  // R9 fifteen bits
        '{4'd4,  5'd16, 16'h01FF, 1'b1, 1'b1, 8'hBC}   // R4 bits 6,1,0 masked
    };

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic open_frame(input logic m3, input logic wp);
        @(negedge clk);
        sck  = m3;
        wp_n = wp;
        @(negedge clk);
        cs_n = 1'b0;
        @(negedge clk);
    endtask

    task automatic shift_bits(input logic [15:0] bits, input int nb, input logic m3);
        for (int i = 0; i < nb; i++) begin
            sck = 1'b0;
            si  = bits[15-i];
            @(negedge clk);
            sck = 1'b1;
            @(negedge clk);
        end
        if (!m3) begin
            sck = 1'b0;
            @(negedge clk);
        end
    endtask

    task automatic close_frame();
        @(negedge clk);
        cs_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=hung expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset status", status, 8'h00);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 status after reset release", status, 8'h00);

        for (int v = 0; v < NV; v++) begin
            open_frame(VT[v].m3, VT[v].wp);
            shift_bits(VT[v].bits, int'(VT[v].nb), VT[v].m3);
            close_frame();
            chk($sformatf("R%0d table vector %0d", VT[v].req, v), status, VT[v].exp);
            chk("R11 so_oe low", {7'd0, so_oe}, 8'h00);
        end

        // R12: aborted partial frame, then a clean enable
        open_frame(1'b0, 1'b1);
        shift_bits(16'h0100, 3, 1'b0);
        close_frame();
        chk("R12 aborted frame no effect", status, 8'hBC);
        open_frame(1'b0, 1'b1);
        shift_bits(16'h0600, 8, 1'b0);
        close_frame();
        chk("R12 next frame from bit zero", status, 8'hBE);

        // R10: no update before chip select rises
        open_frame(1'b1, 1'b1);
        shift_bits(16'h0120, 16, 1'b1);
        repeat (3) @(negedge clk);
        chk("R10 held while cs low", status, 8'hBE);
        chk("R11 so_oe low mid frame", {7'd0, so_oe}, 8'h00);
        close_frame();
        chk("R10 committed at cs rise", status, 8'h20);

        finish_run();
    end

endmodule